// File: doc/BRIEF.md
# Register-Array Binary Content-Addressable Memory

This block is an exact-match lookup table made of plain flip-flops and per-bit equality gates. It holds a parameterized number of words (16 words of 8 bits by default). Each word has its own valid bit. A write port stores a word into a chosen slot, or clears that slot's valid bit, in a single cycle. No reordering or preparation step is needed.

A search presents a key together with a strobe. The key is compared against every stored word at the same time, and each slot produces its own hit line. A lowest-index-first encoder reduces the hit lines to one address and a hit flag. Both are registered and appear one cycle after the strobe. When no slot hits, the address output takes a fixed default value and the flag is low, so a miss can be told apart from a hit on the last slot.

Top module: `lbcam`

## Requirements
- R1: After reset every slot is invalid; a search then returns hit flag 0 and the default address (parameter MISS_ADDR, all ones by default).
- R2: A write with wr_en=1, wr_keep=1 stores wr_word into slot wr_addr and marks it valid in one cycle; a search issued on the next cycle can find it.
- R3: A slot's hit line is asserted only when it is valid and all of its bits equal the key; a word that differs in any single bit does not hit.
- R4: When several valid slots hold the key, the reported address is the lowest matching slot index.
- R5: When no valid slot matches, hit flag is 0 and the address output equals MISS_ADDR.
- R6: A write with wr_en=1, wr_keep=0 deletes slot wr_addr (clears its valid bit), so that slot no longer hits.
- R7: The address and hit flag are registered: they reflect a search strobed in cycle t from cycle t+1 on, and hold their value while no strobe is given.
- R8: If a write and a search happen in the same cycle, the search uses the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_keep | input | 1 | 1 = store word and mark valid, 0 = delete slot |
| wr_addr | input | AW | Slot index to update |
| wr_word | input | W | Word to store |
| srch_go | input | 1 | Search strobe |
| srch_key | input | W | Key to compare |
| res_addr | output | AW | Lowest matching slot, or MISS_ADDR on a miss |
| res_hit | output | 1 | 1 when any valid slot matched |

## Verification
The bench builds the block with its defaults: 16 slots of 8 bits, and a default address equal to the last slot's index. With that miss address, a hit on slot 15 and a miss differ only in the flag, so a design that drops the flag or mixes the two cases is exposed. With only 256 possible keys, random writes often produce duplicates. That regularly exercises lowest-index resolution, stale-versus-new contents under simultaneous write and search, and single-bit near misses.

// File: rtl/lbcam.sv
module lbcam #(
  parameter int N = 16,
  parameter int W = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1,
  parameter logic [AW-1:0] MISS_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_keep,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          srch_go,
  input  logic [W-1:0]  srch_key,
  output logic [AW-1:0] res_addr,
  output logic          res_hit
);
  logic [W-1:0]  word_q [N];
  logic [N-1:0]  vld_q;
  logic [N-1:0]  hit_line;
  logic [AW-1:0] enc_addr;
  logic          enc_any;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [W-1:0] eq_bits;
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign eq_bits[b] = ~(word_q[i][b] ^ srch_key[b]);
    end
    assign hit_line[i] = vld_q[i] & (&eq_bits);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        word_q[i] <= '0;
      end else if (wr_en && wr_addr == AW'(i)) begin
        vld_q[i] <= wr_keep;
        if (wr_keep) word_q[i] <= wr_word;
      end
    end
  end

  always_comb begin
    enc_addr = MISS_ADDR;
    enc_any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_line[i]) begin
        enc_addr = AW'(i);
        enc_any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_addr <= MISS_ADDR;
      res_hit  <= 1'b0;
    end else if (srch_go) begin
      res_addr <= enc_addr;
      res_hit  <= enc_any;
    end
  end

  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_addr == MISS_ADDR) else $error("miss addr"); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_go |=> $stable(res_addr) && $stable(res_hit)) else $error("hold"); // R7
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    srch_go && vld_q == '0 |=> !res_hit) else $error("invalid hit"); // R3
  AST_DELETE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_keep |=> !vld_q[$past(wr_addr)]) else $error("delete"); // R6
  AST_STORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_keep |=> vld_q[$past(wr_addr)] && word_q[$past(wr_addr)] == $past(wr_word)) else $error("store"); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    srch_go && hit_line[0] |=> res_hit && res_addr == '0) else $error("prio"); // R4
endmodule

// File: tb/lbcam_tb.sv
module lbcam_tb_top;
  localparam int N = 16, W = 8, AW = 4;
  localparam logic [AW-1:0] MISS = '1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_keep = 0, srch_go = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_word = '0, srch_key = '0;
  logic [AW-1:0] res_addr;
  logic res_hit;

  int checks = 0, fails = 0;
  logic [W-1:0] m_word [N];
  logic [N-1:0] m_vld;

  always #4 clk = ~clk;

  lbcam #(.N(N), .W(W)) dut_i (.*);

  function automatic logic [AW:0] ref_search(logic [W-1:0] k);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_word[i] == k) return {1'b1, AW'(i)};
    return {1'b0, MISS};
  endfunction

  task automatic check(string req, logic [AW:0] got, logic [AW:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%0b addr=%0d, expected hit=%0b addr=%0d",
               req, got[AW], got[AW-1:0], exp[AW], exp[AW-1:0]);
    end
  endtask

  // one cycle: drive at negedge, commit at posedge, sample after
  task automatic step(logic we, logic keep, logic [AW-1:0] a, logic [W-1:0] d,
                      logic sg, logic [W-1:0] k, string req);
    logic [AW:0] exp;
    @(negedge clk);
    wr_en = we; wr_keep = keep; wr_addr = a; wr_word = d;
    srch_go = sg; srch_key = k;
    exp = ref_search(k);   // pre-write contents (R8)
    @(posedge clk);
    if (we) begin m_vld[a] = keep; if (keep) m_word[a] = d; end
    #1;
    if (sg) check(req, {res_hit, res_addr}, exp);
    wr_en = 0; srch_go = 0;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [AW:0] held;
    void'($urandom(32'd1234));
    m_vld = '0;
    for (int i = 0; i < N; i++) m_word[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {res_hit, res_addr}, {1'b0, MISS});
    rst_n = 1;
    step(0, 0, 0, 0, 1, 8'h00, "R1 empty search");
    step(1, 1, 4'd15, 8'h3C, 0, 0, "");
    step(0, 0, 0, 0, 1, 8'h3C, "R2 hit slot 15");
    check("R5 flag distinguishes slot15", {res_hit, res_addr}, {1'b1, 4'd15});
    step(0, 0, 0, 0, 1, 8'h3D, "R3 one-bit miss");
    check("R5 miss default", {res_hit, res_addr}, {1'b0, MISS});
    step(1, 1, 4'd9, 8'h3C, 0, 0, "");
    step(1, 1, 4'd4, 8'h3C, 0, 0, "");
    step(0, 0, 0, 0, 1, 8'h3C, "R4 lowest index");
    check("R4 lowest is 4", {res_hit, res_addr}, {1'b1, 4'd4});
    step(1, 0, 4'd4, 0, 1, 8'h3C, "R8 search before delete");
    step(0, 0, 0, 0, 1, 8'h3C, "R6 deleted slot skipped");
    check("R6 next is 9", {res_hit, res_addr}, {1'b1, 4'd9});
    step(1, 1, 4'd2, 8'hA5, 1, 8'hA5, "R8 search before store");
    step(0, 0, 0, 0, 1, 8'hA5, "R2 stored next cycle");
    held = {res_hit, res_addr};
    step(0, 0, 0, 0, 0, 0, "");
    step(1, 0, 4'd2, 0, 0, 0, "");
    check("R7 hold without strobe", {res_hit, res_addr}, held);
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] k;
      int s;
      s = $urandom_range(0, N - 1);
      k = ($urandom_range(0, 3) == 0) ? (m_word[s] ^ (8'h1 << $urandom_range(0, 7)))
                                       : m_word[s];
      step($urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0,
           AW'($urandom_range(0, N - 1)), W'($urandom_range(0, 7)),
           $urandom_range(0, 2) != 0, k, "R3 R4 R5 R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule